// File: doc/BRIEF.md
# Symmetric 63-Tap Decimating FIR with Complex-to-Real Mode

This block is a programmable FIR filter for complex I/Q sample streams. It has 63 taps whose coefficients are symmetric about the centre tap. Only 32 coefficient words are stored: word j (j = 0..30) serves both tap j and tap 62-j, and word 31 is the centre tap. There is no built-in coefficient set. The filter stays silent until all 32 words have been written since reset.

In the default mode the filter decimates by two and emits one filtered complex sample for every two samples it accepts. When the complex-to-real pin is high, the filter does not decimate. Each accepted sample then produces one real output, taken from the filtered stream mixed with a +1, 0, -1, 0 quarter-rate sequence, so the output rate is twice that of the default mode.

The arithmetic is time-multiplexed. The two samples that share a coefficient are added before the multiply, with one multiplier each for I and Q. A result takes 32 multiply-accumulate cycles. The result is rounded half-up and saturated to the output width.

The input and output ports are valid/ready streams. An input is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle. An output is taken on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the pending output is held, and no further input is accepted until that output leaves.

`c2r_mode` must be held stable between resets. Coefficient writes are plain single-cycle strobes and take effect at once.

Top module: `sym_dec_fir`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `out_valid` stays 0 until every one of the 32 coefficient addresses has been written since reset. Samples offered before that are still accepted and shifted into the delay line, and the outputs they would have produced are dropped.
- R3: With `c2r_mode`=0, outputs are produced only on the second of each pair of accepted samples, counting from reset. The full-precision I and Q results are each sum over k=0..62 of h[k]*x[n-k], where x[n] is the newest sample, h[k]=word k for k<=31 and h[k]=word 62-k for k>31. Both samples and coefficients are signed two's complement.
- R4: The 16-bit output is (acc + 2^14) >> 15 (arithmetic shift, round half-up), saturated to the range -32768..32767.
- R5: With `c2r_mode`=1, every accepted sample produces one output and `out_q` is 0. With yI and yQ the rounded results of R3/R4, `out_i` cycles through yI, -yQ, -yI, yQ, starting at yI after reset. A negation saturates, so -(-32768) gives 32767.
- R6: `in_ready` stays 1 after an accepted sample that produces no output. After an accepted sample that produces an output, `in_ready` is 0 for at least 32 cycles.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_i` and `out_q` stay unchanged.
- R8: A coefficient write while the block is idle is used by the very next computed output.
- R9: The delay line holds zeros after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 5 | Coefficient word index (31 = centre tap) |
| coef_data | input | 16 | Signed coefficient, 1.15 format |
| c2r_mode | input | 1 | 1 = complex-to-real, no decimation |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_i | input | 16 | Input in-phase sample |
| in_q | input | 16 | Input quadrature sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts output |
| out_i | output | 16 | Output in-phase / real sample |
| out_q | output | 16 | Output quadrature sample (0 in real mode) |

## Verification
A stale or wrong coefficient word, or a wrong pairing of mirrored taps, corrupts the very next output value. Such a fault is caught at the first output after the sample or write that exposes it. A slip in the decimation phase or in the mixer index shows up as a wrong value within two outputs. It can also show as an output count that does not match the number of accepted samples. A broken load mask shows either as an output before the 32nd distinct write or as silence after it. Both are visible within one 34-cycle computation.

// File: rtl/pfir_pkg.sv
package pfir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MAC  = 2'd1,
    ST_FIN  = 2'd2,
    ST_OUT  = 2'd3
  } pfir_state_e;
endpackage

// File: rtl/pfir_coef_store.sv
module pfir_coef_store #(
  parameter int NU  = 32,
  parameter int CW  = 16,
  localparam int CAW = $clog2(NU)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CAW-1:0]       wr_addr,
  input  logic [CW-1:0]        wr_data,
  input  logic [CAW-1:0]       rd_addr,
  output logic signed [CW-1:0] rd_data,
  output logic                 full
);
  logic [CW-1:0] mem [NU];
  logic [NU-1:0] seen;

  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < NU)) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (wr_en && (int'(wr_addr) < NU)) seen[wr_addr] <= 1'b1;
  end

  assign full    = &seen;
  assign rd_data = mem[rd_addr];

  // R2
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(wr_en));
endmodule

// File: rtl/pfir_tap_line.sv
module pfir_tap_line #(
  parameter int DW = 16,
  parameter int NT = 63,
  localparam int NU  = (NT + 1) / 2,
  localparam int CAW = $clog2(NU),
  localparam int LW  = $clog2(NT)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift,
  input  logic [DW-1:0]        din_i,
  input  logic [DW-1:0]        din_q,
  input  logic [CAW-1:0]       sel,
  output logic signed [DW:0]   pre_i,
  output logic signed [DW:0]   pre_q
);
  logic signed [DW-1:0] line_i [NT];
  logic signed [DW-1:0] line_q [NT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_i[0] <= '0;
      line_q[0] <= '0;
    end else if (shift) begin
      line_i[0] <= din_i;
      line_q[0] <= din_q;
    end
  end

  for (genvar g = 1; g < NT; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        line_i[g] <= '0;
        line_q[g] <= '0;
      end else if (shift) begin
        line_i[g] <= line_i[g-1];
        line_q[g] <= line_q[g-1];
      end
    end
  end

  logic [LW-1:0] idx_a, idx_b;
  logic          is_ctr;
  logic signed [DW:0] a_i, b_i, a_q, b_q;

  always_comb begin
    idx_a  = LW'(sel);
    idx_b  = LW'(NT - 1) - LW'(sel);
    is_ctr = (int'(sel) == NU - 1);
    a_i = {line_i[idx_a][DW-1], line_i[idx_a]};
    a_q = {line_q[idx_a][DW-1], line_q[idx_a]};
    b_i = is_ctr ? '0 : {line_i[idx_b][DW-1], line_i[idx_b]};
    b_q = is_ctr ? '0 : {line_q[idx_b][DW-1], line_q[idx_b]};
    pre_i = a_i + b_i;
    pre_q = a_q + b_q;
  end
endmodule

// File: rtl/pfir_mac.sv
module pfir_mac #(
  parameter int PW    = 17,
  parameter int CW    = 16,
  parameter int ACC_W = 38
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [PW-1:0]    pre,
  input  logic signed [CW-1:0]    coef,
  output logic signed [ACC_W-1:0] acc
);
  logic signed [PW+CW-1:0] prod;
  assign prod = pre * coef;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (en)       acc <= acc + ACC_W'(prod);
  end
endmodule

// File: rtl/pfir_out_shaper.sv
module pfir_out_shaper #(
  parameter int ACC_W = 38,
  parameter int OW    = 16,
  parameter int SHIFT = 15
) (
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic signed [ACC_W-1:0] acc_q,
  input  logic                    c2r,
  input  logic [1:0]              mix,
  output logic [OW-1:0]           res_i,
  output logic [OW-1:0]           res_q
);
  localparam logic signed [ACC_W:0] HALF =
    {{(ACC_W + 1 - SHIFT){1'b0}}, 1'b1, {(SHIFT - 1){1'b0}}};
  localparam logic signed [ACC_W:0] MAXV =
    {{(ACC_W + 2 - OW){1'b0}}, {(OW - 1){1'b1}}};
  localparam logic signed [ACC_W:0] MINV =
    {{(ACC_W + 2 - OW){1'b1}}, {(OW - 1){1'b0}}};
  localparam logic [OW-1:0] OMIN = {1'b1, {(OW - 1){1'b0}}};
  localparam logic [OW-1:0] OMAX = {1'b0, {(OW - 1){1'b1}}};

  function automatic logic [OW-1:0] rnd_sat(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W:0] r;
    r = {a[ACC_W-1], a} + HALF;
    r = r >>> SHIFT;
    if (r > MAXV)      return MAXV[OW-1:0];
    else if (r < MINV) return MINV[OW-1:0];
    else               return r[OW-1:0];
  endfunction

  function automatic logic [OW-1:0] neg_sat(input logic [OW-1:0] v);
    if (v == OMIN) return OMAX;
    else           return (~v) + OW'(1);
  endfunction

  logic [OW-1:0] yi, yq;

  always_comb begin
    yi = rnd_sat(acc_i);
    yq = rnd_sat(acc_q);
    if (!c2r) begin
      res_i = yi;
      res_q = yq;
    end else begin
      res_q = '0;
      case (mix)
        2'd0:    res_i = yi;
        2'd1:    res_i = neg_sat(yq);
        2'd2:    res_i = neg_sat(yi);
        default: res_i = yq;
      endcase
    end
  end
endmodule

// File: rtl/sym_dec_fir.sv
module sym_dec_fir
  import pfir_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int OW = 16,
  parameter int NT = 63,
  localparam int NU    = (NT + 1) / 2,
  localparam int CAW   = $clog2(NU),
  localparam int PW    = DW + 1,
  localparam int ACC_W = PW + CW + $clog2(NU),
  localparam int SHIFT = CW - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           coef_we,
  input  logic [CAW-1:0] coef_addr,
  input  logic [CW-1:0]  coef_data,
  input  logic           c2r_mode,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_i,
  input  logic [DW-1:0]  in_q,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [OW-1:0]  out_i,
  output logic [OW-1:0]  out_q
);
  pfir_state_e st;
  logic [CAW-1:0] cnt;
  logic           phase;
  logic [1:0]     mix, cur_mix;
  logic           accept, coef_full;
  logic signed [CW-1:0]    coef_rd;
  logic signed [PW-1:0]    pre [2];
  logic signed [ACC_W-1:0] acc [2];
  logic [OW-1:0]  res_i, res_q;

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_OUT);
  assign accept    = in_ready && in_valid;

  pfir_coef_store #(.NU(NU), .CW(CW)) u_coef (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_we), .wr_addr(coef_addr),
    .wr_data(coef_data), .rd_addr(cnt), .rd_data(coef_rd), .full(coef_full)
  );

  pfir_tap_line #(.DW(DW), .NT(NT)) u_line (
    .clk(clk), .rst_n(rst_n), .shift(accept), .din_i(in_i), .din_q(in_q),
    .sel(cnt), .pre_i(pre[0]), .pre_q(pre[1])
  );

  for (genvar p = 0; p < 2; p++) begin : g_path
    pfir_mac #(.PW(PW), .CW(CW), .ACC_W(ACC_W)) u_mac (
      .clk(clk), .rst_n(rst_n), .clr(accept), .en(st == ST_MAC),
      .pre(pre[p]), .coef(coef_rd), .acc(acc[p])
    );
  end

  pfir_out_shaper #(.ACC_W(ACC_W), .OW(OW), .SHIFT(SHIFT)) u_shape (
    .acc_i(acc[0]), .acc_q(acc[1]), .c2r(c2r_mode), .mix(cur_mix),
    .res_i(res_i), .res_q(res_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      phase   <= 1'b0;
      mix     <= 2'd0;
      cur_mix <= 2'd0;
      out_i   <= '0;
      out_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (in_valid) begin
          cnt <= '0;
          if (c2r_mode) begin
            cur_mix <= mix;
            mix     <= mix + 2'd1;
            st      <= ST_MAC;
          end else begin
            phase <= ~phase;
            if (phase) st <= ST_MAC;
          end
        end
        ST_MAC: begin
          cnt <= cnt + CAW'(1);
          if (cnt == CAW'(NU - 1)) st <= ST_FIN;
        end
        ST_FIN: begin
          if (coef_full) begin
            out_i <= res_i;
            out_q <= res_q;
            st    <= ST_OUT;
          end else begin
            st <= ST_IDLE;
          end
        end
        default: if (out_ready) st <= ST_IDLE;
      endcase
    end
  end

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q));

  // R2
  out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> coef_full);

  // R5
  c2r_q_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && c2r_mode |-> out_q == '0);

  // R6
  busy_after_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (c2r_mode || phase) |=> !in_ready && !out_valid);
endmodule

// File: tb/sym_dec_fir_bench.sv
module sym_dec_fir_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coef_we = 1'b0;
  logic [4:0] coef_addr = '0;
  logic [15:0] coef_data = '0;
  logic c2r_mode = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [15:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [15:0] out_i, out_q;

  sym_dec_fir u_sym_dec_fir (
    .clk(clk), .rst_n(rst_n), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .c2r_mode(c2r_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_i(in_i), .in_q(in_q), .out_valid(out_valid),
    .out_ready(out_ready), .out_i(out_i), .out_q(out_q)
  );

  initial forever #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  string tag = "R3";

  longint hist_i [63], hist_q [63];
  longint coefs [32];
  logic [31:0] mask;
  bit m_phase;
  int m_mix;
  logic [15:0] exp_i_q [$], exp_q_q [$];
  int outs_seen = 0;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint filt(input bit use_q);
    longint s = 0;
    for (int k = 0; k < 63; k++)
      s += coefs[(k <= 31) ? k : 62 - k] * (use_q ? hist_q[k] : hist_i[k]);
    return sat16((s + 16384) >>> 15);
  endfunction

  task automatic model_accept(input logic [15:0] vi, input logic [15:0] vq,
                              output bit due);
    longint yi, yq, r;
    for (int k = 62; k > 0; k--) begin
      hist_i[k] = hist_i[k-1];
      hist_q[k] = hist_q[k-1];
    end
    hist_i[0] = longint'($signed(vi));
    hist_q[0] = longint'($signed(vq));
    if (c2r_mode) begin
      due = 1;
    end else begin
      due = m_phase;
      m_phase = ~m_phase;
    end
    if (due && (&mask)) begin
      yi = filt(0);
      yq = filt(1);
      if (c2r_mode) begin
        case (m_mix)
          0: r = yi;
          1: r = sat16(-yq);
          2: r = sat16(-yi);
          default: r = yq;
        endcase
        exp_i_q.push_back(16'(r));
        exp_q_q.push_back(16'd0);
      end else begin
        exp_i_q.push_back(16'(yi));
        exp_q_q.push_back(16'(yq));
      end
    end
    if (c2r_mode) m_mix = (m_mix + 1) % 4;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    in_valid = 0;
    coef_we = 0;
    for (int k = 0; k < 63; k++) begin
      hist_i[k] = 0;
      hist_q[k] = 0;
    end
    mask = '0;
    m_phase = 0;
    m_mix = 0;
    exp_i_q.delete();
    exp_q_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr_coef(input int a, input logic [15:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    coef_we = 1;
    coef_addr = 5'(a);
    coef_data = d;
    @(posedge clk);
    coefs[a] = longint'($signed(d));
    mask[a] = 1'b1;
    @(negedge clk);
    coef_we = 0;
  endtask

  task automatic send(input logic [15:0] vi, input logic [15:0] vq);
    bit due;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1;
    in_i = vi;
    in_q = vq;
    @(posedge clk);
    model_accept(vi, vq, due);
    @(negedge clk);
    in_valid = 0;
    // R6: an accept that yields no output leaves in_ready high
    if (!due) check(in_ready == 1'b1, "R6", "in_ready after non-output accept", in_ready, 1);
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_i_q.size() != 0 || !in_ready) && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Output consumer: random back-pressure, compare in order
  initial begin
    bit held = 0;
    logic [15:0] hi = '0, hq = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        held = 0;
        out_ready = 0;
      end else begin
        if (held) begin
          // R7: stall keeps output stable
          check(out_valid && out_i == hi && out_q == hq, "R7", "held output",
                longint'($signed(out_i)), longint'($signed(hi)));
        end
        out_ready = ($urandom_range(0, 3) != 0);
        if (out_valid) begin
          outs_seen++;
          if (!(&mask)) begin
            check(0, "R2", "out_valid before full load", 1, 0);
          end else if (out_ready) begin
            if (exp_i_q.size() == 0) begin
              check(0, tag, "unexpected output", longint'($signed(out_i)), 0);
            end else begin
              logic [15:0] ei, eq;
              ei = exp_i_q.pop_front();
              eq = exp_q_q.pop_front();
              check(out_i == ei, tag, "out_i", longint'($signed(out_i)), longint'($signed(ei)));
              check(out_q == eq, tag, "out_q", longint'($signed(out_q)), longint'($signed(eq)));
            end
          end
        end
        held = out_valid && !out_ready;
        hi = out_i;
        hq = out_q;
      end
    end
  end

  // R6 monitor: a busy period lasts at least 32 cycles
  initial begin
    int low = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) low = 0;
      else if (!in_ready) low++;
      else begin
        if (low > 0) check(low >= 32, "R6", "in_ready low span", low, 32);
        low = 0;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_F1F0));
    for (int k = 0; k < 32; k++) coefs[k] = 0;
    do_reset();
    @(negedge clk);
    // R1: reset state
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);

    // R2: no coefficients, then 31 of 32: still silent
    tag = "R2";
    for (int n = 0; n < 6; n++) send(16'($urandom), 16'($urandom));
    for (int k = 0; k < 31; k++) wr_coef(k, 16'($urandom_range(0, 8000)));
    for (int n = 0; n < 4; n++) send(16'($urandom), 16'($urandom));
    repeat (40) @(negedge clk);
    check(outs_seen == 0, "R2", "outputs while partly loaded", outs_seen, 0);

    // R4: centre tap 0.5 exercises half-up rounding
    tag = "R4";
    for (int k = 0; k < 31; k++) wr_coef(k, 16'd0);
    wr_coef(31, 16'd16384);
    for (int n = 0; n < 70; n++) send(16'(n[0] ? -3 : 3), 16'(n[1] ? 5 : -5));
    drain();
    check(outs_seen > 0, "R2", "outputs once fully loaded", outs_seen, 1);

    // R3: random coefficients and samples
    tag = "R3";
    for (int k = 0; k < 32; k++) wr_coef(k, 16'($urandom_range(0, 65535) >> 2));
    for (int n = 0; n < 160; n++) send(16'($urandom), 16'($urandom));
    drain();

    // R8: a coefficient write takes effect at the next output
    tag = "R8";
    for (int n = 0; n < 6; n++) begin
      wr_coef($urandom_range(0, 31), 16'($urandom));
      send(16'($urandom), 16'($urandom));
      send(16'($urandom), 16'($urandom));
    end
    drain();

    // R4: saturation at both rails
    tag = "R4";
    for (int k = 0; k < 32; k++) wr_coef(k, 16'd32767);
    for (int n = 0; n < 64; n++) send(16'd32767, 16'h8000);
    drain();
    check(exp_i_q.size() == 0, "R3", "pending outputs after normal run", exp_i_q.size(), 0);

    // R5 and R9: complex-to-real after a fresh reset
    c2r_mode = 1;
    do_reset();
    tag = "R9";
    for (int k = 0; k < 32; k++) wr_coef(k, 16'($urandom_range(0, 65535) >> 3));
    for (int n = 0; n < 8; n++) send(16'($urandom), 16'($urandom));
    drain();
    tag = "R5";
    outs_seen = 0;
    for (int n = 0; n < 80; n++) send(16'($urandom), 16'($urandom));
    drain();
    check(outs_seen >= 80, "R5", "one output per accepted sample", outs_seen, 80);
    // R5: saturated negation of the negative rail
    wr_coef(0, 16'd32767);
    wr_coef(31, 16'd32767);
    for (int k = 1; k < 31; k++) wr_coef(k, 16'd0);
    for (int n = 0; n < 72; n++) send(16'h8000, 16'h8000);
    drain();
    check(exp_i_q.size() == 0, "R5", "pending outputs after real run", exp_i_q.size(), 0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule